// File: doc/BRIEF.md
# Credit-Throttled Block Data Pump

This block moves a configuration image into a device data register during the data phase of a load. The controlling sequencer gives it a byte count and a start pulse. The image words then arrive on a valid/ready stream. Each word is written to the device through a simple request/acknowledge register port. When the transfer ends, the pump reports the outcome with a one-cycle done pulse and a result code.

The image is sent in blocks. In throttled mode a block is `BLOCK_BYTES` long. Before each block the pump reads the device's 8-bit credit register and compares it with the low byte of its own count of blocks sent. While there is no space it reads the device status register, waits a programmable number of cycles, and tries again. It gives up after a programmable total wait. In unthrottled mode every word is its own 4-byte block and no credit is read. If the image length is not a whole number of words, the last word is sent with its unused upper bytes forced to zero. An optional error check reads the device status at fixed byte intervals and once more at the end of the image.

Top module: `cfg_block_pump`

## Requirements
- R1: After reset, and whenever `busy` is low, `reg_req`, `s_ready` and `done` are 0 and `err_code` is 0 until a transfer ends with an error.
- R2: Throttled mode (`throttle_mode`=1): exactly one credit read (address 1) precedes the first word of each block, and a block holds `BLOCK_BYTES` bytes (the last block holds what remains). Unthrottled mode: no credit read is ever issued.
- R3: A block may start when (credit[7:0] − sent[7:0]) mod 256 is nonzero. `sent` is the count of blocks written; it is cleared at `start` and incremented after the last word of every block, and the comparison wraps past 255.
- R4: No stream word is accepted (`s_ready` stays 0) and no data write is issued while the pump waits for credit. `s_ready` and `reg_req` are never high together.
- R5: After each credit read that shows no space, the status register (address 2) is read. If its bit 0 is 1, the transfer ends with `err_code`=1 (retry).
- R6: Consecutive credit reads are separated by at least `probe_gap` idle cycles. When the cycles spent waiting for the current block reach `credit_limit` and no credit has been seen, the transfer ends with `err_code`=2 (timeout).
- R7: For an image of n bytes, ceil(n/4) words are written. In a final word that carries 1 to 3 bytes, the byte lanes at or above the remaining count are zero (byte 0 is bits 7:0).
- R8: With `err_check_en`=1, status is read after every `CHECK_BYTES` bytes written while more bytes remain, and once after the last word. A read with bit 0 set ends the transfer with `err_code`=3. With `err_check_en`=0, status is read only after failed credit probes.
- R9: `done` is high for exactly one cycle per transfer. `err_code` is valid from then until the next `start`. A zero-length image gives `done` with code 0 and no data write.
- R10: Register requests hold `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` stable until `reg_ack`. Writes go only to address 0 (data). Credit (address 1) and status (address 2) are reads.
- R11: Words are written in stream order, each exactly once, with the unmasked bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (one-cycle pulse, while idle) |
| byte_count | input | BYTE_W | Image length in bytes, sampled at start |
| throttle_mode | input | 1 | 1: credit-throttled large blocks, 0: single-word blocks |
| err_check_en | input | 1 | Enable interval and end-of-image status checks |
| probe_gap | input | GAP_W | Idle cycles between credit probes |
| credit_limit | input | WAIT_W | Cycles of credit wait per block before timeout |
| s_data | input | 32 | Image word stream data |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high with s_valid |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 for write, 0 for read |
| reg_addr | output | 2 | 0 data, 1 credit, 2 status |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | One-cycle acknowledge of the request |
| reg_rdata | input | 32 | Read data, valid with reg_ack |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_code | output | 2 | 0 ok, 1 retry, 2 timeout, 3 config error |

## Verification
The bench builds the pump with `BLOCK_BYTES`=16 and `CHECK_BYTES`=32. With these values a few hundred bytes cover several full blocks, partial last blocks and interval checks that land both mid-image and exactly at the end. A 300-block image drives the 8-bit credit comparison through its wrap in a few thousand cycles. A `probe_gap` of 20 and a `credit_limit` of 150 keep the stall, probe-spacing and timeout cases short enough to bound in cycles.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BLK,
    ST_CRD,
    ST_ERRP,
    ST_GAP,
    ST_WORD,
    ST_WR,
    ST_CHK,
    ST_FIN
  } pump_state_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_RETRY   = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_CFGERR  = 2'd3
  } pump_result_e;

  localparam logic [1:0] RA_DATA   = 2'd0;
  localparam logic [1:0] RA_CREDIT = 2'd1;
  localparam logic [1:0] RA_STATUS = 2'd2;

endpackage

// File: rtl/cbp_word_shaper.sv
module cbp_word_shaper #(
  parameter int BYTE_W = 32
) (
  input  logic [31:0]       word_i,
  input  logic [BYTE_W-1:0] bytes_left_i,
  output logic [31:0]       word_o,
  output logic [2:0]        nbytes_o
);

  // bytes carried by the word now at the head of the image
  always_comb begin
    if (bytes_left_i >= BYTE_W'(4)) nbytes_o = 3'd4;
    else                            nbytes_o = {1'b0, bytes_left_i[1:0]};
  end

  // each byte lane passes only if it lies inside the remaining length
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign word_o[8*g +: 8] = (bytes_left_i > BYTE_W'(g)) ? word_i[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/cbp_credit_gate.sv
module cbp_credit_gate #(
  parameter int GAP_W  = 16,
  parameter int WAIT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAP_W-1:0]  probe_gap_i,
  input  logic [WAIT_W-1:0] wait_limit_i,
  input  logic [7:0]        credit_i,
  input  logic [7:0]        sent_i,
  input  logic              wait_clr_i,
  input  logic              wait_run_i,
  input  logic              gap_load_i,
  input  logic              gap_run_i,
  output logic              space_o,
  output logic              gap_done_o,
  output logic              wait_over_o
);

  logic [7:0]        diff;
  logic [GAP_W-1:0]  gap_cnt_q, gap_cnt_d;
  logic [WAIT_W-1:0] wait_cnt_q, wait_cnt_d;
  logic              gap_en, wait_en;

  // modulo-256 distance between granted and consumed blocks
  assign diff    = credit_i - sent_i;
  assign space_o = (diff != 8'd0);

  always_comb begin
    gap_en    = 1'b0;
    gap_cnt_d = gap_cnt_q;
    if (gap_load_i) begin
      gap_en    = 1'b1;
      gap_cnt_d = probe_gap_i;
    end else if (gap_run_i && (gap_cnt_q != '0)) begin
      gap_en    = 1'b1;
      gap_cnt_d = gap_cnt_q - GAP_W'(1);
    end
  end

  always_comb begin
    wait_en    = 1'b0;
    wait_cnt_d = wait_cnt_q;
    if (wait_clr_i) begin
      wait_en    = 1'b1;
      wait_cnt_d = '0;
    end else if (wait_run_i && (wait_cnt_q != '1)) begin
      wait_en    = 1'b1;
      wait_cnt_d = wait_cnt_q + WAIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_cnt_q <= '0;
    else if (gap_en) gap_cnt_q <= gap_cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_cnt_q <= '0;
    else if (wait_en) wait_cnt_q <= wait_cnt_d;
  end

  assign gap_done_o  = (gap_cnt_q == '0);
  assign wait_over_o = (wait_cnt_q >= wait_limit_i);

endmodule

// File: rtl/cfg_block_pump.sv
module cfg_block_pump
  import cbp_pkg::*;
#(
  parameter int BLOCK_BYTES = 4096,
  parameter int CHECK_BYTES = 4096,
  parameter int BYTE_W      = 32,
  parameter int GAP_W       = 16,
  parameter int WAIT_W      = 24,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] byte_count,
  input  logic              throttle_mode,
  input  logic              err_check_en,
  input  logic [GAP_W-1:0]  probe_gap,
  input  logic [WAIT_W-1:0] credit_limit,
  input  logic [31:0]       s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              reg_req,
  output logic              reg_we,
  output logic [1:0]        reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [31:0]       reg_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);

  localparam int BLK_W = $clog2(BLOCK_BYTES + 1);
  localparam logic [BYTE_W-1:0] CHK_MASK = BYTE_W'(CHECK_BYTES - 1);

  pump_state_e  state_q, state_d;
  pump_result_e code_q, code_d;
  logic [BYTE_W-1:0] rem_q, rem_d;
  logic [BYTE_W-1:0] sum_q, sum_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [CNT_W-1:0]  sent_q, sent_d;
  logic [31:0]       wdata_q, wdata_d;
  logic              thr_q, thr_d;
  logic              chk_q, chk_d;

  logic [31:0]       shaped;
  logic [2:0]        nb;
  logic [BYTE_W-1:0] sum_next;
  logic              space, gap_done, wait_over;
  logic              wait_clr, wait_run, gap_load, gap_run;

  cbp_word_shaper #(.BYTE_W(BYTE_W)) i_shaper (
    .word_i       (s_data),
    .bytes_left_i (rem_q),
    .word_o       (shaped),
    .nbytes_o     (nb)
  );

  cbp_credit_gate #(.GAP_W(GAP_W), .WAIT_W(WAIT_W)) i_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .probe_gap_i  (probe_gap),
    .wait_limit_i (credit_limit),
    .credit_i     (reg_rdata[7:0]),
    .sent_i       (sent_q[7:0]),
    .wait_clr_i   (wait_clr),
    .wait_run_i   (wait_run),
    .gap_load_i   (gap_load),
    .gap_run_i    (gap_run),
    .space_o      (space),
    .gap_done_o   (gap_done),
    .wait_over_o  (wait_over)
  );

  assign sum_next = sum_q + BYTE_W'(nb);

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    rem_d    = rem_q;
    sum_d    = sum_q;
    blk_d    = blk_q;
    sent_d   = sent_q;
    wdata_d  = wdata_q;
    thr_d    = thr_q;
    chk_d    = chk_q;
    reg_req  = 1'b0;
    reg_we   = 1'b0;
    reg_addr = RA_CREDIT;
    s_ready  = 1'b0;
    wait_clr = 1'b0;
    wait_run = 1'b0;
    gap_load = 1'b0;
    gap_run  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          rem_d   = byte_count;
          sum_d   = '0;
          sent_d  = '0;
          code_d  = RES_OK;
          thr_d   = throttle_mode;
          chk_d   = err_check_en;
          state_d = ST_BLK;
        end
      end

      ST_BLK: begin
        if (rem_q == '0) begin
          state_d = chk_q ? ST_CHK : ST_FIN;
        end else begin
          wait_clr = 1'b1;
          if (thr_q) begin
            if (rem_q >= BYTE_W'(BLOCK_BYTES)) blk_d = BLK_W'(BLOCK_BYTES);
            else                               blk_d = BLK_W'(rem_q);
            state_d = ST_CRD;
          end else begin
            blk_d   = BLK_W'(nb);
            state_d = ST_WORD;
          end
        end
      end

      ST_CRD: begin
        reg_req  = 1'b1;
        reg_addr = RA_CREDIT;
        wait_run = 1'b1;
        if (reg_ack) state_d = space ? ST_WORD : ST_ERRP;
      end

      ST_ERRP: begin
        reg_req  = 1'b1;
        reg_addr = RA_STATUS;
        wait_run = 1'b1;
        if (reg_ack) begin
          if (reg_rdata[0]) begin
            code_d  = RES_RETRY;
            state_d = ST_FIN;
          end else begin
            gap_load = 1'b1;
            state_d  = ST_GAP;
          end
        end
      end

      ST_GAP: begin
        wait_run = 1'b1;
        gap_run  = 1'b1;
        if (gap_done) begin
          if (wait_over) begin
            code_d  = RES_TIMEOUT;
            state_d = ST_FIN;
          end else begin
            state_d = ST_CRD;
          end
        end
      end

      ST_WORD: begin
        s_ready = 1'b1;
        if (s_valid) begin
          wdata_d = shaped;
          state_d = ST_WR;
        end
      end

      ST_WR: begin
        reg_req  = 1'b1;
        reg_we   = 1'b1;
        reg_addr = RA_DATA;
        if (reg_ack) begin
          rem_d = rem_q - BYTE_W'(nb);
          sum_d = sum_next;
          blk_d = blk_q - BLK_W'(nb);
          if (blk_q == BLK_W'(nb)) begin
            sent_d = sent_q + CNT_W'(1);
            if (chk_q && (rem_q != BYTE_W'(nb)) && ((sum_next & CHK_MASK) == '0))
              state_d = ST_CHK;
            else
              state_d = ST_BLK;
          end else begin
            state_d = ST_WORD;
          end
        end
      end

      ST_CHK: begin
        reg_req  = 1'b1;
        reg_addr = RA_STATUS;
        if (reg_ack) begin
          if (reg_rdata[0]) begin
            code_d  = RES_CFGERR;
            state_d = ST_FIN;
          end else begin
            state_d = (rem_q == '0) ? ST_FIN : ST_BLK;
          end
        end
      end

      ST_FIN: state_d = ST_IDLE;

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= RES_OK;
      rem_q   <= '0;
      sum_q   <= '0;
      blk_q   <= '0;
      sent_q  <= '0;
      wdata_q <= '0;
      thr_q   <= 1'b0;
      chk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      rem_q   <= rem_d;
      sum_q   <= sum_d;
      blk_q   <= blk_d;
      sent_q  <= sent_d;
      wdata_q <= wdata_d;
      thr_q   <= thr_d;
      chk_q   <= chk_d;
    end
  end

  assign reg_wdata = wdata_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err_code  = code_q;

endmodule

// File: rtl/cbp_pump_checker.sv
module cbp_pump_checker
  import cbp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        throttle_mode,
  input logic        s_ready,
  input logic        reg_req,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        reg_ack,
  input logic        busy,
  input logic        done
);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

  assert_write_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> (reg_addr == RA_DATA));

  assert_no_stream_while_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && reg_req));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_credit_unthrottled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && (reg_addr == RA_CREDIT)) |-> throttle_mode);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_req && !s_ready));

endmodule

bind cfg_block_pump cbp_pump_checker i_pump_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .throttle_mode (throttle_mode),
  .s_ready       (s_ready),
  .reg_req       (reg_req),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_ack       (reg_ack),
  .busy          (busy),
  .done          (done)
);

// File: tb/test_cfg_block_pump.sv
`timescale 1ns/1ps
module test_cfg_block_pump;

  localparam int BLK = 16;
  localparam int CHK = 32;
  localparam int WPB = BLK / 4;
  localparam int MAXW = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] byte_count = '0;
  logic        throttle_mode = 1'b0;
  logic        err_check_en = 1'b0;
  logic [15:0] probe_gap = '0;
  logic [23:0] credit_limit = '0;
  logic [31:0] s_data;
  logic        s_valid;
  logic        s_ready;
  logic        reg_req, reg_we, reg_ack;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        busy, done;
  logic [1:0]  err_code;

  always #2.5 clk = ~clk;

  cfg_block_pump #(.BLOCK_BYTES(BLK), .CHECK_BYTES(CHK)) i_cfg_block_pump (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .throttle_mode(throttle_mode), .err_check_en(err_check_en),
    .probe_gap(probe_gap), .credit_limit(credit_limit),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .err_code(err_code)
  );

  // bench-owned device model and stream source
  logic [31:0] img    [0:MAXW-1];
  logic [31:0] logged [0:MAXW-1];
  int   n_log, cred_reads, stat_reads, idx, lat;
  logic stat_err_q;
  logic clr = 1'b0, src_en = 1'b0, auto_cred = 1'b1, stat_force = 1'b0;
  logic [7:0] frozen_cred = '0;
  int   err_at = 0;
  int   n_chk = 0, n_fail = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ack <= 1'b0; reg_rdata <= '0; lat <= 0; n_log <= 0;
      cred_reads <= 0; stat_reads <= 0; stat_err_q <= 1'b0;
    end else if (clr) begin
      reg_ack <= 1'b0; n_log <= 0; cred_reads <= 0; stat_reads <= 0; stat_err_q <= 1'b0;
    end else if (reg_req && !reg_ack) begin
      if (lat == 0) begin
        reg_ack <= 1'b1;
        lat <= int'($urandom % 3);
        case (reg_addr)
          2'd0: begin
            if (n_log < MAXW) logged[n_log] <= reg_wdata;
            n_log <= n_log + 1;
            if (err_at != 0 && n_log + 1 == err_at) stat_err_q <= 1'b1;
            reg_rdata <= '0;
          end
          2'd1: begin
            cred_reads <= cred_reads + 1;
            reg_rdata <= {24'h0, auto_cred ? 8'((n_log / WPB) + 1) : frozen_cred};
          end
          default: begin
            stat_reads <= stat_reads + 1;
            reg_rdata <= {31'h0, stat_err_q | stat_force};
          end
        endcase
      end else begin
        lat <= lat - 1;
      end
    end else begin
      reg_ack <= 1'b0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= 0; s_valid <= 1'b0;
    end else begin
      if (clr) idx <= 0;
      else if (s_valid && s_ready) idx <= idx + 1;
      s_valid <= src_en && (($urandom % 4) != 0);
    end
  end
  assign s_data = img[idx % MAXW];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int i, input int n);
    int left = n - 4 * i;
    logic [31:0] w = img[i];
    for (int b = 0; b < 4; b++) if (b >= left) w[8*b +: 8] = 8'h00;
    return w;
  endfunction

  task automatic fill(input int words);
    for (int i = 0; i < words && i < MAXW; i++) img[i] = $urandom;
  endtask

  task automatic kick(input int n, input bit thr, input bit chk, input int limit, input int gap);
    @(negedge clk);
    byte_count = n; throttle_mode = thr; err_check_en = chk;
    credit_limit = 24'(limit); probe_gap = 16'(gap); clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; start = 1'b1; src_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int code, output int cyc);
    cyc = 1;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    check(done == 1'b1, "R9 done seen", int'(done), 1);
    code = int'(err_code);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    src_en = 1'b0;
  endtask

  task automatic check_data(input int n, input string req);
    int words = (n + 3) / 4;
    int bad = 0;
    check(n_log == words, {req, " word count"}, n_log, words);
    for (int i = 0; i < words && i < n_log; i++) if (logged[i] !== exp_word(i, n)) bad++;
    check(bad == 0, {req, " word data"}, bad, 0);
  endtask

  task automatic good_xfer(input int n, input bit thr, input string req);
    int code, cyc;
    fill((n + 3) / 4);
    auto_cred = 1'b1; stat_force = 1'b0; err_at = 0;
    kick(n, thr, 1'b0, 100000, 20);
    wait_done(code, cyc);
    check(code == 0, {req, " code"}, code, 0);
    check_data(n, req);
    if (thr) check(cred_reads == (n + BLK - 1) / BLK, "R2 one credit read per block", cred_reads, (n + BLK - 1) / BLK);
    else     check(cred_reads == 0, "R2 no credit read unthrottled", cred_reads, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int code, cyc;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    check(reg_req == 1'b0 && s_ready == 1'b0 && done == 1'b0 && err_code == 2'd0,
          "R1 reset state", int'({reg_req, s_ready, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && reg_req == 1'b0, "R1 idle after reset", int'(busy), 0);

    // R9 zero length
    auto_cred = 1'b1; err_at = 0; stat_force = 1'b0;
    kick(0, 1'b1, 1'b0, 1000, 4);
    wait_done(code, cyc);
    check(code == 0, "R9 zero length code", code, 0);
    check(n_log == 0, "R9 zero length no write", n_log, 0);

    // R7 tail lengths, both modes
    for (int r = 0; r < 4; r++) begin
      good_xfer(40 + r, 1'b1, "R7 tail throttled");
      good_xfer(9 + r, 1'b0, "R7 tail unthrottled");
    end

    // R11 random lengths and modes
    for (int t = 0; t < 20; t++)
      good_xfer(int'($urandom % 150) + 1, 1'($urandom % 2), "R11 random");

    // R3 credit wrap past 255 blocks
    good_xfer(BLK * 300, 1'b1, "R3 wrap");

    // R4 / R6 stall then release
    fill(12);
    auto_cred = 1'b0; frozen_cred = 8'd0; stat_force = 1'b0; err_at = 0;
    kick(48, 1'b1, 1'b0, 100000, 20);
    repeat (200) @(negedge clk);
    check(n_log == 0, "R4 no write without credit", n_log, 0);
    check(idx == 0, "R4 no stream word taken while stalled", idx, 0);
    check(stat_reads == cred_reads, "R5 status read per failed probe", stat_reads, cred_reads);
    check(cred_reads >= 3 && cred_reads <= 10, "R6 probe spacing", cred_reads, 8);
    auto_cred = 1'b1;
    wait_done(code, cyc);
    check(code == 0, "R4 stall release code", code, 0);
    check_data(48, "R4 stall release");

    // R6 timeout
    auto_cred = 1'b0; frozen_cred = 8'd0;
    kick(32, 1'b1, 1'b0, 150, 20);
    wait_done(code, cyc);
    check(code == 2, "R6 timeout code", code, 2);
    check(cyc >= 150 && cyc <= 200, "R6 timeout window", cyc, 150);
    check(n_log == 0, "R6 timeout no write", n_log, 0);

    // R5 retry abort on error during stall
    stat_force = 1'b1;
    kick(32, 1'b1, 1'b0, 100000, 20);
    wait_done(code, cyc);
    check(code == 1, "R5 retry code", code, 1);
    check(cred_reads == 1, "R5 single probe before abort", cred_reads, 1);
    stat_force = 1'b0; auto_cred = 1'b1;

    // R8 interval check catches error
    fill(16); err_at = 3;
    kick(64, 1'b1, 1'b1, 100000, 20);
    wait_done(code, cyc);
    check(code == 3, "R8 interval error code", code, 3);
    check(n_log == CHK / 4, "R8 stop at interval", n_log, CHK / 4);

    // R8 end-of-image check
    fill(5); err_at = 5;
    kick(20, 1'b1, 1'b1, 100000, 20);
    wait_done(code, cyc);
    check(code == 3, "R8 end check code", code, 3);
    check(n_log == 5, "R8 end check words", n_log, 5);

    // R8 disabled: same error ignored
    kick(20, 1'b1, 1'b0, 100000, 20);
    wait_done(code, cyc);
    check(code == 0, "R8 disabled code", code, 0);
    check(stat_reads == 0, "R8 disabled no status read", stat_reads, 0);

    // R8 enabled, no error: one mid check plus one end check
    fill(16); err_at = 0;
    kick(64, 1'b1, 1'b1, 100000, 20);
    wait_done(code, cyc);
    check(code == 0, "R8 clean code", code, 0);
    check(stat_reads == 2, "R8 check count", stat_reads, 2);
    check_data(64, "R8 clean");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule